// File: doc/BRIEF.md
# Byte-Wide EPROM Mode Decoder with Identifier Readout

This block is a clocked, synthesizable behavioural model of the control side of a byte-wide ultraviolet-erasable EPROM. On every clock edge it samples the chip-select and output-enable strobes (both active low), a flag that says the programming supply is raised, and a flag that says address bit 9 carries an over-voltage. From these it selects one of seven operating modes: read, output disable, standby, program, program verify, program inhibit and identifier readout. All outputs are registered and change on the edge after the inputs they respond to.

In read and verify modes the block returns the stored byte. In the identifier mode it returns one of two fixed codes, chosen by address bit 0. In program mode it can only clear stored bits to zero. An erase strobe returns the whole array to all ones. A drive-enable output reports when the data pins would be actively driven, so that a surrounding model can check for bus contention. The array holds `2**MEM_AW` bytes. The 15-bit address wraps onto the array by its low `MEM_AW` bits.

Top module: `eprom_ctrl`

## Requirements
- R1: With ce_n=0, oe_n=0, vpp_hi=0 and a9_hv=0 sampled at a clock edge, dout_en is 1 after that edge and dout equals the stored byte at word addr[MEM_AW-1:0]. The upper address bits alias onto the same word.
- R2: With ce_n=1 sampled, dout_en is 0 after that edge, whatever oe_n, vpp_hi and a9_hv are.
- R3: The stored contents change only in program mode or on an erase strobe. Output disable (ce_n=0, oe_n=1, vpp_hi=0), standby and program inhibit (ce_n=1, oe_n=1, vpp_hi=1) leave every byte unchanged.
- R4: Program mode is ce_n=0, oe_n=1, vpp_hi=1. At each such edge the addressed byte becomes old AND din, so bits only go from one to zero. dout_en is 0 after the edge.
- R5: Program verify is ce_n=0, oe_n=0, vpp_hi=1. It drives the stored byte like a read. vpp_hi takes precedence over a9_hv, so the identifier mode is not entered while vpp_hi=1.
- R6: Identifier readout is ce_n=0, oe_n=0, vpp_hi=0, a9_hv=1, with every address bit other than bit 0 and bit 9 at zero. It drives 8'h01 when addr[0]=0 and 8'h10 when addr[0]=1. Both codes have odd parity over all eight bits, with bit 7 acting as the parity bit.
- R7: An identifier access with any address bit other than bit 0 or bit 9 set is illegal. After the edge, id_fault is 1 and dout_en is 0. In every other case id_fault is 0.
- R8: erase_req=1 at an edge sets every byte to 8'hFF from the next edge on. A program pulse in the same edge is discarded. A read or verify in the same edge returns the contents from before the erase.
- R9: deep_standby is 1 after an edge that sampled ce_n=1 together with cmos_sel=1, and 0 otherwise.
- R10: dout is 8'h00 whenever dout_en is 0. While rst_n is low, dout, dout_en, id_fault and deep_standby are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr | input | 15 | Byte address |
| din | input | 8 | Byte to program (zeros clear bits) |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| vpp_hi | input | 1 | Programming supply is at its raised level |
| a9_hv | input | 1 | Address bit 9 is at over-voltage (identifier request) |
| cmos_sel | input | 1 | Deselect is at the full-rail level (deep standby) |
| erase_req | input | 1 | Erase the entire array to all ones |
| dout | output | 8 | Registered data out, zero when not driven |
| dout_en | output | 1 | Data pins would be driven |
| id_fault | output | 1 | Illegal identifier address seen |
| deep_standby | output | 1 | Deep standby state |

## Verification
Two events can land on the same clock edge: an erase strobe and an array access, either a program pulse or a read/verify of a byte. The bench provokes this in two ways. It uses directed cycles that assert erase_req alongside a program pulse and alongside a read of a freshly cleared byte. It also draws random cycles in which erase_req is sometimes raised on top of any mode. Each case is judged against a bench model in which the erase wins over the write and the read sees the old byte. A follow-up read then shows that the discarded write left no trace.

// File: rtl/eprom_pkg.sv
package eprom_pkg;

  typedef enum logic [2:0] {
    M_STANDBY,
    M_INHIBIT,
    M_DISABLE,
    M_PROGRAM,
    M_READ,
    M_VERIFY,
    M_IDENT
  } mode_e;

  // Prefix a payload with a parity bit so the whole byte has odd parity.
  function automatic logic [7:0] odd_parity_byte(input logic [6:0] payload);
    return {~^payload, payload};
  endfunction

endpackage

// File: rtl/eprom_mode_dec.sv
module eprom_mode_dec
  import eprom_pkg::*;
(
  input  logic  ce_n,
  input  logic  oe_n,
  input  logic  vpp_hi,
  input  logic  a9_hv,
  output mode_e mode
);

  always_comb begin
    if (ce_n) begin
      mode = (vpp_hi && oe_n) ? M_INHIBIT : M_STANDBY;
    end else if (oe_n) begin
      mode = vpp_hi ? M_PROGRAM : M_DISABLE;
    end else if (vpp_hi) begin
      mode = M_VERIFY;
    end else if (a9_hv) begin
      mode = M_IDENT;
    end else begin
      mode = M_READ;
    end
  end

endmodule

// File: rtl/eprom_id_rom.sv
module eprom_id_rom
  import eprom_pkg::*;
#(
  parameter int unsigned ADDR_W      = 15,
  parameter int unsigned HV_BIT      = 9,
  parameter logic [6:0]  MFR_PAYLOAD = 7'h01,
  parameter logic [6:0]  DEV_PAYLOAD = 7'h10
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [7:0]        id_byte,
  output logic              id_legal
);

  localparam logic [ADDR_W-1:0] FREE_MASK =
    (ADDR_W'(1) << HV_BIT) | ADDR_W'(1);
  localparam logic [7:0] MFR_CODE = odd_parity_byte(MFR_PAYLOAD);
  localparam logic [7:0] DEV_CODE = odd_parity_byte(DEV_PAYLOAD);

  always_comb begin
    id_legal = ((addr & ~FREE_MASK) == '0);
    id_byte  = addr[0] ? DEV_CODE : MFR_CODE;
  end

endmodule

// File: rtl/eprom_cell_array.sv
module eprom_cell_array #(
  parameter int unsigned MEM_AW = 8,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic              erase_en,
  input  logic [MEM_AW-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [MEM_AW-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam int unsigned DEPTH = 1 << MEM_AW;

  logic [DATA_W-1:0] cells [DEPTH];

  for (genvar w = 0; w < DEPTH; w++) begin : g_word
    logic              upd;
    logic [DATA_W-1:0] nxt;

    always_comb begin
      upd = erase_en || (wr_en && (waddr == MEM_AW'(w)));
      nxt = erase_en ? '1 : (cells[w] & wdata);
    end

    always_ff @(posedge clk) begin
      if (upd) begin
        cells[w] <= nxt;
      end
    end
  end

  assign rdata = cells[raddr];

endmodule

// File: rtl/eprom_ctrl.sv
module eprom_ctrl
  import eprom_pkg::*;
#(
  parameter int unsigned ADDR_W      = 15,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned MEM_AW      = 8,
  parameter int unsigned HV_BIT      = 9,
  parameter logic [6:0]  MFR_PAYLOAD = 7'h01,
  parameter logic [6:0]  DEV_PAYLOAD = 7'h10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              vpp_hi,
  input  logic              a9_hv,
  input  logic              cmos_sel,
  input  logic              erase_req,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en,
  output logic              id_fault,
  output logic              deep_standby
);

  // reset: asynchronous assertion, synchronous release
  logic rst_meta, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  mode_e             mode;
  logic [7:0]        id_byte;
  logic              id_legal;
  logic [DATA_W-1:0] cell_q;
  logic              wr_en, erase_en;

  eprom_mode_dec u_dec (
    .ce_n   (ce_n),
    .oe_n   (oe_n),
    .vpp_hi (vpp_hi),
    .a9_hv  (a9_hv),
    .mode   (mode)
  );

  eprom_id_rom #(
    .ADDR_W      (ADDR_W),
    .HV_BIT      (HV_BIT),
    .MFR_PAYLOAD (MFR_PAYLOAD),
    .DEV_PAYLOAD (DEV_PAYLOAD)
  ) u_id (
    .addr     (addr),
    .id_byte  (id_byte),
    .id_legal (id_legal)
  );

  assign erase_en = erase_req && rst_s;
  assign wr_en    = (mode == M_PROGRAM) && rst_s && !erase_req;

  eprom_cell_array #(
    .MEM_AW (MEM_AW),
    .DATA_W (DATA_W)
  ) u_cells (
    .clk      (clk),
    .wr_en    (wr_en),
    .erase_en (erase_en),
    .waddr    (addr[MEM_AW-1:0]),
    .wdata    (din),
    .raddr    (addr[MEM_AW-1:0]),
    .rdata    (cell_q)
  );

  // next-state
  logic [DATA_W-1:0] dout_d;
  logic              en_d, fault_d, deep_d;

  always_comb begin
    dout_d  = '0;
    en_d    = 1'b0;
    fault_d = 1'b0;
    deep_d  = ce_n && cmos_sel;
    unique case (mode)
      M_READ, M_VERIFY: begin
        en_d   = 1'b1;
        dout_d = cell_q;
      end
      M_IDENT: begin
        if (id_legal) begin
          en_d   = 1'b1;
          dout_d = DATA_W'(id_byte);
        end else begin
          fault_d = 1'b1;
        end
      end
      default: begin
        en_d = 1'b0;
      end
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      dout         <= '0;
      dout_en      <= 1'b0;
      id_fault     <= 1'b0;
      deep_standby <= 1'b0;
    end else begin
      dout         <= dout_d;
      dout_en      <= en_d;
      id_fault     <= fault_d;
      deep_standby <= deep_d;
    end
  end

  // assertions
  p_deselect_floats_r2: assert property (@(posedge clk) disable iff (!rst_s)
    ($past(rst_s) && $past(ce_n)) |-> !dout_en);

  p_read_drives_r1: assert property (@(posedge clk) disable iff (!rst_s)
    ($past(rst_s) && $past(!ce_n && !oe_n && !a9_hv)) |-> dout_en);

  p_program_floats_r4: assert property (@(posedge clk) disable iff (!rst_s)
    ($past(rst_s) && $past(mode == M_PROGRAM)) |-> !dout_en);

  p_id_parity_r6: assert property (@(posedge clk) disable iff (!rst_s)
    ($past(rst_s) && $past(mode == M_IDENT && id_legal)) |-> (dout_en && (^dout)));

  p_fault_floats_r7: assert property (@(posedge clk) disable iff (!rst_s)
    id_fault |-> !dout_en);

  p_idle_zero_r10: assert property (@(posedge clk) disable iff (!rst_s)
    !dout_en |-> (dout == '0));

endmodule

// File: tb/eprom_ctrl_test.sv
`timescale 1ns/1ps
module eprom_ctrl_test;

  localparam int MEM_AW = 8;
  localparam int DEPTH  = 1 << MEM_AW;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [14:0] addr;
  logic [7:0]  din;
  logic        ce_n, oe_n, vpp_hi, a9_hv, cmos_sel, erase_req;
  logic [7:0]  dout;
  logic        dout_en, id_fault, deep_standby;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  logic [7:0] model [DEPTH];

  always #2.5 clk = ~clk;

  eprom_ctrl #(.MEM_AW(MEM_AW)) uut (
    .clk, .rst_n, .addr, .din, .ce_n, .oe_n, .vpp_hi, .a9_hv,
    .cmos_sel, .erase_req, .dout, .dout_en, .id_fault, .deep_standby
  );

  task automatic chk(input string tag, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // 0 standby 1 inhibit 2 disable 3 program 4 read 5 verify 6 ident
  function automatic int mode_of(input logic c, input logic o,
                                 input logic v, input logic h);
    if (c) return (v && o) ? 1 : 0;
    if (o) return v ? 3 : 2;
    if (v) return 5;
    if (h) return 6;
    return 4;
  endfunction

  function automatic bit id_ok(input logic [14:0] a);
    return (a & ~15'h0201) == 15'h0;
  endfunction

  function automatic string tag_of(input int m, input logic [14:0] a);
    case (m)
      0: return "R2";
      1: return "R3";
      2: return "R3";
      3: return "R4";
      4: return "R1";
      5: return "R5";
      default: return id_ok(a) ? "R6" : "R7";
    endcase
  endfunction

  task automatic step(input string tag, input logic c, input logic o,
                      input logic v, input logic h, input logic [14:0] a,
                      input logic [7:0] d, input logic er, input logic cm);
    int         m;
    logic [7:0] e_dout;
    logic       e_en, e_fault, e_deep;
    string      t;
    @(negedge clk);
    ce_n = c; oe_n = o; vpp_hi = v; a9_hv = h; addr = a; din = d;
    erase_req = er; cmos_sel = cm;
    m = mode_of(c, o, v, h);
    t = (tag == "") ? tag_of(m, a) : tag;
    e_en = 1'b0; e_dout = 8'h00; e_fault = 1'b0;
    e_deep = c && cm;
    if (m == 4 || m == 5) begin
      e_en = 1'b1; e_dout = model[a[MEM_AW-1:0]];
    end else if (m == 6) begin
      if (id_ok(a)) begin
        e_en = 1'b1; e_dout = a[0] ? 8'h10 : 8'h01;
      end else begin
        e_fault = 1'b1;
      end
    end
    @(posedge clk);
    @(negedge clk);
    chk(t, "dout_en", {7'b0, dout_en}, {7'b0, e_en});
    chk(t, "dout", dout, e_dout);
    chk((m == 6) ? t : "R7", "id_fault", {7'b0, id_fault}, {7'b0, e_fault});
    chk("R9", "deep_standby", {7'b0, deep_standby}, {7'b0, e_deep});
    if (er) begin
      for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
    end else if (m == 3) begin
      model[a[MEM_AW-1:0]] = model[a[MEM_AW-1:0]] & d;
    end
  endtask

  task automatic rd(input string tag, input logic [14:0] a);
    step(tag, 1'b0, 1'b0, 1'b0, 1'b0, a, 8'h00, 1'b0, 1'b0);
  endtask

  initial begin
    #200000;
    if (!finished) begin
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20240611);
    rst_n = 1'b0; ce_n = 1'b1; oe_n = 1'b1; vpp_hi = 1'b0; a9_hv = 1'b0;
    addr = '0; din = '0; cmos_sel = 1'b1; erase_req = 1'b0;
    for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R10 reset state
    chk("R10", "reset dout", dout, 8'h00);
    chk("R10", "reset dout_en", {7'b0, dout_en}, 8'h00);
    chk("R10", "reset id_fault", {7'b0, id_fault}, 8'h00);
    chk("R10", "reset deep_standby", {7'b0, deep_standby}, 8'h00);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R8 erase then read ones
    step("R8", 1'b1, 1'b1, 1'b0, 1'b0, 15'h0, 8'h00, 1'b1, 1'b0);
    rd("R8", 15'h0003);
    rd("R8", 15'h00FF);
    // R4 program clears only
    step("R4", 1'b0, 1'b1, 1'b1, 1'b0, 15'h0003, 8'h5A, 1'b0, 1'b0);
    step("R4", 1'b0, 1'b1, 1'b1, 1'b0, 15'h0003, 8'hF0, 1'b0, 1'b0);
    rd("R4", 15'h0003);
    // R1 aliasing
    rd("R1", 15'h0103);
    rd("R1", 15'h7F03);
    // R5 verify, with a9 over-voltage ignored
    step("R5", 1'b0, 1'b0, 1'b1, 1'b0, 15'h0003, 8'h00, 1'b0, 1'b0);
    step("R5", 1'b0, 1'b0, 1'b1, 1'b1, 15'h0000, 8'h00, 1'b0, 1'b0);
    // R6 identifiers, bit 9 allowed
    step("R6", 1'b0, 1'b0, 1'b0, 1'b1, 15'h0000, 8'h00, 1'b0, 1'b0);
    step("R6", 1'b0, 1'b0, 1'b0, 1'b1, 15'h0001, 8'h00, 1'b0, 1'b0);
    step("R6", 1'b0, 1'b0, 1'b0, 1'b1, 15'h0201, 8'h00, 1'b0, 1'b0);
    // R7 illegal identifier addresses
    step("R7", 1'b0, 1'b0, 1'b0, 1'b1, 15'h0020, 8'h00, 1'b0, 1'b0);
    step("R7", 1'b0, 1'b0, 1'b0, 1'b1, 15'h4001, 8'h00, 1'b0, 1'b0);
    // R2 standby floats with oe low, a9 and vpp; R9 kind
    step("R2", 1'b1, 1'b0, 1'b0, 1'b1, 15'h0003, 8'h00, 1'b0, 1'b1);
    step("R2", 1'b1, 1'b0, 1'b1, 1'b0, 15'h0003, 8'h00, 1'b0, 1'b0);
    // R3 inhibit and disable leave contents
    step("R3", 1'b1, 1'b1, 1'b1, 1'b0, 15'h0003, 8'h00, 1'b0, 1'b0);
    step("R3", 1'b0, 1'b1, 1'b0, 1'b0, 15'h0003, 8'h00, 1'b0, 1'b0);
    rd("R3", 15'h0003);
    // R8 collisions: erase with read returns old, erase with program discards
    step("R4", 1'b0, 1'b1, 1'b1, 1'b0, 15'h0010, 8'h0F, 1'b0, 1'b0);
    step("R8", 1'b0, 1'b0, 1'b0, 1'b0, 15'h0010, 8'h00, 1'b1, 1'b0);
    rd("R8", 15'h0010);
    step("R8", 1'b0, 1'b1, 1'b1, 1'b0, 15'h0011, 8'h00, 1'b1, 1'b0);
    rd("R8", 15'h0011);

    // constrained random
    for (int k = 0; k < 4000; k++) begin
      logic        c, o, v, h, er, cm;
      logic [14:0] a;
      c  = ($urandom % 4) == 0;
      o  = ($urandom % 2) == 0;
      v  = ($urandom % 5) == 0;
      h  = ($urandom % 4) == 0;
      er = ($urandom % 150) == 0;
      cm = ($urandom % 2) == 0;
      if (h && ($urandom % 3) != 0) a = {5'b0, 1'($urandom), 8'b0, 1'($urandom)};
      else a = 15'($urandom);
      step("", c, o, v, h, a, 8'($urandom), er, cm);
    end

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

endmodule